// File: doc/BRIEF.md
# Linear Sensor Line Readout Sequencer

This block sits on the host side of a photodiode line sensor. The sensor needs a slow clock and a one-clock start pulse. The block derives both from the fast system clock and sequences one line readout per start. For each active pixel it also gives an ADC sample strobe tagged with a pixel index. It flags the end of every line, so the capture logic that follows knows when a line is complete.

A line begins on a start request, or runs back to back while continuous mode is held. Four settings are captured at the start of each line and then held until the line ends:

- the half-period of the sensor clock, in system clocks;
- the integration time, in sensor clocks;
- the strobe delay, in system clocks;
- serial or parallel readout.

The sensor clears its integrators during the first 18 clocks of a readout, and integration for the next line starts on clock 19. The block therefore stretches each line with extra sensor clocks until the requested integration time has passed before the next start pulse. Every line also carries one trailing clock after the last pixel, which ends the sensor's output phase.

The sensor clock must stay between 5 kHz and 8 MHz. Each clock phase must last at least 50 ns, and the start pulse needs 20 ns of setup. Choosing a half-period that meets these limits is left to the integrator. For example, with a 125 MHz system clock a half-period of 7 or more meets the 50 ns limit.

Top module: `linescan_host`

## Requirements
- R1: After reset, and whenever no line is running, sensClk, sensStart, adcStrobe, lineDone and busy are all low.
- R2: While a line runs, every high phase and every low phase of sensClk lasts exactly H system clocks. H is the captured cfgHalfDiv, and a value of 0 is treated as 1.
- R3: sensStart rises while sensClk is low, stays high for exactly 2H system clocks, and falls in the same cycle as the first falling edge of sensClk. It is therefore high at the first rising edge of the line and at no other rising edge.
- R4: Let N be the pixel count: 256 when cfgParallel is 0 (serial) and 128 when cfgParallel is 1 (parallel). Let T be cfgIntegClks. A line has exactly max(N+1, 18+T) rising edges of sensClk.
- R5: Each line produces exactly N one-cycle adcStrobe pulses. The pulse for rising edge k (k = 1..N) comes D system clocks after the first cycle in which sensClk is high, where D is the captured cfgStrobeDly and D < 2H. pixelIdx equals k-1 during that pulse.
- R6: If contMode is high when a line ends, the next line starts without a gap. sensStart is already high in the lineDone cycle, and successive first rising edges are 2H·max(N+1, 18+T) system clocks apart.
- R7: lineDone is a one-cycle pulse. It is asserted in the first cycle that sensClk is low after the final rising edge. busy is high at every rising edge of a line, and a line that does not continue ends with busy low in its lineDone cycle.
- R8: The configuration inputs are captured only when a line starts. Changing them during a line does not change that line's phase length, edge count, strobe count, strobe delay or start pulse.
- R9: A startReq pulse that arrives while a line is running is ignored. When that line ends, busy and sensClk stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request one line; acted on when idle or in the cycle a line ends |
| contMode | input | 1 | Keep starting lines back to back while high |
| cfgParallel | input | 1 | 1: 128 clocks per line; 0: 256 clocks per line |
| cfgHalfDiv | input | 16 | Sensor clock half-period in system clocks (0 acts as 1) |
| cfgIntegClks | input | 20 | Integration time in sensor clocks, counted from clock 19 to the next start edge |
| cfgStrobeDly | input | 8 | System clocks from a sensor clock rising edge to the strobe |
| sensClk | output | 1 | Clock to the sensor |
| sensStart | output | 1 | Start pulse to the sensor |
| adcStrobe | output | 1 | One-cycle ADC sample strobe |
| pixelIdx | output | 8 | Pixel index for the current strobe |
| busy | output | 1 | A line is in progress |
| lineDone | output | 1 | One-cycle end-of-line pulse |

## Verification
The bench aims at the boundary where the integration request just equals the readout length, and at the next value above it. A design that counted the 18-clock reset window off by one would give a line one edge too short or too long there.

It runs each half-period with strobe delays of zero and of 2H-1. A late or early strobe would shift the measured delay, and a strobe on the trailing clock would raise the strobe count above N.

Configuration inputs are scrambled in the middle of a line, and a stray start is injected mid-line. A design that used live settings would change its phase lengths, and one that honoured the stray start would chain a second line.

Back-to-back continuous lines check that the start pulse is already up in the lineDone cycle and that the line spacing is exact.

// File: rtl/lsh_pkg.sv
package lsh_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } lshState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic startLine;  // capture config, raise start pulse, clear counters
    logic stopLine;   // last edge done and no follow-on line
    logic running;    // a line is in progress
  } lshCtl_t;

endpackage

// File: rtl/lsh_ctrl.sv
module lsh_ctrl
  import lsh_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    contMode,
  input  logic    lastFall,
  output lshCtl_t ctl,
  output logic    busy,
  output logic    lineDone
);

  lshState_e state;
  logic      go;

  assign go = startReq | contMode;

  always_comb begin
    ctl.running   = (state == ST_RUN);
    ctl.startLine = go && ((state == ST_IDLE) || lastFall);
    ctl.stopLine  = lastFall && !go;
  end

  assign busy = ctl.running;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      lineDone <= 1'b0;
    end else begin
      lineDone <= lastFall;
      if (ctl.startLine)     state <= ST_RUN;
      else if (ctl.stopLine) state <= ST_IDLE;
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |=> !lineDone);

  // R7
  done_in_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastFall |-> (state == ST_RUN));

endmodule

// File: rtl/lsh_datapath.sv
module lsh_datapath
  import lsh_pkg::*;
#(
  parameter int PIX_SERIAL   = 256,
  parameter int PIX_PARALLEL = 128,
  parameter int RESET_CLKS   = 18,
  parameter int DIV_W        = 16,
  parameter int INT_W        = 20,
  parameter int DLY_W        = 8,
  parameter int IDX_W        = $clog2(PIX_SERIAL)
)(
  input  logic             clk,
  input  logic             rstN,
  input  lshCtl_t          ctl,
  input  logic             cfgParallel,
  input  logic [DIV_W-1:0] cfgHalfDiv,
  input  logic [INT_W-1:0] cfgIntegClks,
  input  logic [DLY_W-1:0] cfgStrobeDly,
  output logic             sensClk,
  output logic             sensStart,
  output logic             adcStrobe,
  output logic [IDX_W-1:0] pixelIdx,
  output logic             lastFall
);

  localparam int PIX_W  = IDX_W + 1;
  localparam int EDGE_W = INT_W + 2;
  localparam logic [PIX_W-1:0] PIX_S = PIX_W'(PIX_SERIAL);
  localparam logic [PIX_W-1:0] PIX_P = PIX_W'(PIX_PARALLEL);

  // captured line configuration
  logic [DIV_W-1:0]  halfLat;
  logic [DLY_W-1:0]  dlyLat;
  logic [PIX_W-1:0]  pixLat;
  logic [EDGE_W-1:0] edgeTotLat;

  // next-line configuration
  logic [DIV_W-1:0]  halfNext;
  logic [PIX_W-1:0]  pixNext;
  logic [EDGE_W-1:0] floorEdges, integEdges, edgeNext;

  always_comb begin
    halfNext   = (cfgHalfDiv == '0) ? DIV_W'(1) : cfgHalfDiv;
    pixNext    = cfgParallel ? PIX_P : PIX_S;
    floorEdges = EDGE_W'(pixNext) + EDGE_W'(1);
    integEdges = EDGE_W'(RESET_CLKS) + EDGE_W'(cfgIntegClks);
    edgeNext   = (integEdges > floorEdges) ? integEdges : floorEdges;
  end

  // clock generation state
  logic [DIV_W-1:0]  phaseCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic              phaseEnd;
  logic [DLY_W-1:0]  dlyCnt;
  logic [IDX_W-1:0]  pendIdx;

  assign phaseEnd = (phaseCnt == halfLat - DIV_W'(1));
  assign lastFall = ctl.running && sensClk && phaseEnd && (edgeCnt == edgeTotLat);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfLat    <= DIV_W'(1);
      dlyLat     <= '0;
      pixLat     <= PIX_S;
      edgeTotLat <= '0;
      phaseCnt   <= '0;
      edgeCnt    <= '0;
      sensClk    <= 1'b0;
      sensStart  <= 1'b0;
      adcStrobe  <= 1'b0;
      pixelIdx   <= '0;
      dlyCnt     <= '0;
      pendIdx    <= '0;
    end else begin
      adcStrobe <= 1'b0;
      // delayed strobe countdown
      if (dlyCnt != '0) begin
        dlyCnt <= dlyCnt - DLY_W'(1);
        if (dlyCnt == DLY_W'(1)) begin
          adcStrobe <= 1'b1;
          pixelIdx  <= pendIdx;
        end
      end
      if (ctl.startLine) begin
        halfLat    <= halfNext;
        dlyLat     <= cfgStrobeDly;
        pixLat     <= pixNext;
        edgeTotLat <= edgeNext;
        phaseCnt   <= '0;
        edgeCnt    <= '0;
        sensClk    <= 1'b0;
        sensStart  <= 1'b1;
      end else if (ctl.stopLine) begin
        phaseCnt  <= '0;
        edgeCnt   <= '0;
        sensClk   <= 1'b0;
        sensStart <= 1'b0;
      end else if (ctl.running) begin
        if (phaseEnd) begin
          phaseCnt <= '0;
          sensClk  <= !sensClk;
          if (!sensClk) begin
            edgeCnt <= edgeCnt + EDGE_W'(1);
            if (edgeCnt < EDGE_W'(pixLat)) begin
              if (dlyLat == '0) begin
                adcStrobe <= 1'b1;
                pixelIdx  <= edgeCnt[IDX_W-1:0];
              end else begin
                dlyCnt  <= dlyLat;
                pendIdx <= edgeCnt[IDX_W-1:0];
              end
            end
          end else begin
            sensStart <= 1'b0;
          end
        end else begin
          phaseCnt <= phaseCnt + DIV_W'(1);
        end
      end
    end
  end

  // R3
  start_rise_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sensStart) |-> !sensClk);

  // R3
  start_fall_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sensStart) |-> $fell(sensClk));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.running |-> (!sensClk && !adcStrobe));

  // R5
  strobe_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcStrobe |-> (PIX_W'(pixelIdx) < pixLat));

  // R4
  edge_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt <= edgeTotLat);

endmodule

// File: rtl/linescan_host.sv
module linescan_host
  import lsh_pkg::*;
#(
  parameter int PIX_SERIAL   = 256,
  parameter int PIX_PARALLEL = 128,
  parameter int RESET_CLKS   = 18,
  parameter int DIV_W        = 16,
  parameter int INT_W        = 20,
  parameter int DLY_W        = 8,
  parameter int IDX_W        = $clog2(PIX_SERIAL)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             contMode,
  input  logic             cfgParallel,
  input  logic [DIV_W-1:0] cfgHalfDiv,
  input  logic [INT_W-1:0] cfgIntegClks,
  input  logic [DLY_W-1:0] cfgStrobeDly,
  output logic             sensClk,
  output logic             sensStart,
  output logic             adcStrobe,
  output logic [IDX_W-1:0] pixelIdx,
  output logic             busy,
  output logic             lineDone
);

  lshCtl_t ctl;
  logic    lastFall;

  lsh_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .contMode (contMode),
    .lastFall (lastFall),
    .ctl      (ctl),
    .busy     (busy),
    .lineDone (lineDone)
  );

  lsh_datapath #(
    .PIX_SERIAL   (PIX_SERIAL),
    .PIX_PARALLEL (PIX_PARALLEL),
    .RESET_CLKS   (RESET_CLKS),
    .DIV_W        (DIV_W),
    .INT_W        (INT_W),
    .DLY_W        (DLY_W),
    .IDX_W        (IDX_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .cfgParallel  (cfgParallel),
    .cfgHalfDiv   (cfgHalfDiv),
    .cfgIntegClks (cfgIntegClks),
    .cfgStrobeDly (cfgStrobeDly),
    .sensClk      (sensClk),
    .sensStart    (sensStart),
    .adcStrobe    (adcStrobe),
    .pixelIdx     (pixelIdx),
    .lastFall     (lastFall)
  );

endmodule

// File: tb/linescan_host_test.sv
module linescan_host_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        contMode = 1'b0;
  logic        cfgParallel = 1'b0;
  logic [15:0] cfgHalfDiv = 16'd1;
  logic [19:0] cfgIntegClks = '0;
  logic [7:0]  cfgStrobeDly = '0;
  logic        sensClk, sensStart, adcStrobe, busy, lineDone;
  logic [7:0]  pixelIdx;

  always #4 clk = ~clk;

  linescan_host uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .contMode(contMode),
    .cfgParallel(cfgParallel), .cfgHalfDiv(cfgHalfDiv),
    .cfgIntegClks(cfgIntegClks), .cfgStrobeDly(cfgStrobeDly),
    .sensClk(sensClk), .sensStart(sensStart), .adcStrobe(adcStrobe),
    .pixelIdx(pixelIdx), .busy(busy), .lineDone(lineDone)
  );

  int total = 0, bad = 0;
  int expH = 1, expD = 0, expN = 256, expRises = 257, expBusy = 0;
  int cyc = 0, lineCnt = 0;
  int rises = 0, strobes = 0, idxBad = 0, dlyBad = 0, siLen = 0, siRises = 0;
  int phaseBad = 0, busyBad = 0, runLen = 0, sinceRise = 0, lastSiCyc = 0;
  bit siFirstOk = 0, prevClk = 0, gapArm = 0, contPhase = 0;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int edgesFor(input int n, input int integ);
    return (18 + integ > n + 1) ? 18 + integ : n + 1;
  endfunction

  // line monitor, samples between clock edges
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (rstN) begin
      if (sensClk != prevClk) begin
        if (prevClk) begin
          if (runLen != expH) phaseBad++;
          sinceRise++;
        end else begin
          if (rises > 0 && runLen != expH) phaseBad++;
          rises++;
          sinceRise = 0;
          if (!busy) busyBad++;
          if (sensStart) begin
            siRises++;
            siFirstOk = (rises == 1);
            if (gapArm) check("R6 line spacing", cyc - lastSiCyc, 2 * expH * expRises);
            lastSiCyc = cyc;
            gapArm = contPhase;
          end
        end
        runLen = 1;
      end else begin
        runLen++;
        sinceRise++;
      end
      prevClk = sensClk;
      if (lineDone) begin
        check("R2 phase length errors", phaseBad, 0);
        check("R4 rising edges", rises, expRises);
        check("R5 strobe count", strobes, expN);
        check("R5 pixel index errors", idxBad, 0);
        check("R5 strobe delay errors", dlyBad, 0);
        check("R3 start pulse on edge 1 only", int'(siRises == 1 && siFirstOk), 1);
        check("R3 start pulse length", siLen, 2 * expH);
        check("R7 busy at done", int'(busy), expBusy);
        check("R7 busy during line", busyBad, 0);
        if (expBusy == 1) check("R6 start already high", int'(sensStart), 1);
        rises = 0; strobes = 0; idxBad = 0; dlyBad = 0; siLen = 0;
        siRises = 0; phaseBad = 0; busyBad = 0; siFirstOk = 0;
        lineCnt++;
      end
      if (sensStart) siLen++;
      if (adcStrobe) begin
        if (int'(pixelIdx) != strobes) idxBad++;
        if (sinceRise != expD) dlyBad++;
        strobes++;
      end
    end
  end

  task automatic setCfg(input bit par, input int h, input int integ, input int d);
    cfgParallel  = par;
    cfgHalfDiv   = 16'(h);
    cfgIntegClks = 20'(integ);
    cfgStrobeDly = 8'(d);
    expH     = (h == 0) ? 1 : h;
    expD     = d;
    expN     = par ? 128 : 256;
    expRises = edgesFor(expN, integ);
  endtask

  task automatic runLine(input bit par, input int h, input int integ, input int d,
                         input bit scramble, input bit poke);
    int startCnt;
    setCfg(par, h, integ, d);
    expBusy = 0;
    startCnt = lineCnt;
    @(posedge clk); #1 startReq = 1'b1;
    @(posedge clk); #1 startReq = 1'b0;
    if (scramble) begin
      // R8: live inputs change mid-line, expectations keep the captured set
      repeat (4) @(posedge clk);
      #1;
      cfgParallel  = 1'($urandom_range(0, 1));
      cfgHalfDiv   = 16'($urandom_range(1, 9));
      cfgIntegClks = 20'($urandom_range(0, 900));
      cfgStrobeDly = 8'($urandom_range(0, 15));
    end
    if (poke) begin
      repeat (6) @(posedge clk);
      #1 startReq = 1'b1;
      @(posedge clk); #1 startReq = 1'b0;
    end
    while (lineCnt == startCnt) @(posedge clk);
    #1;
    repeat (4) @(posedge clk);
    #1;
    if (poke) begin
      check("R9 busy after stray start", int'(busy), 0);
      check("R9 clock idle after stray start", int'(sensClk), 0);
    end else begin
      check("R1 idle busy after line", int'(busy), 0);
      check("R1 idle clock after line", int'(sensClk), 0);
    end
  endtask

  initial begin
    int startCnt;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 sensClk in reset", int'(sensClk), 0);
    check("R1 sensStart in reset", int'(sensStart), 0);
    check("R1 adcStrobe in reset", int'(adcStrobe), 0);
    check("R1 lineDone in reset", int'(lineDone), 0);
    check("R1 busy in reset", int'(busy), 0);
    rstN = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    check("R1 busy idle after reset", int'(busy), 0);
    check("R1 sensClk idle after reset", int'(sensClk), 0);

    // R4 directed floor boundaries and R2 zero divide
    runLine(1'b0, 1, 239, 0, 1'b0, 1'b0);
    runLine(1'b0, 1, 240, 1, 1'b0, 1'b0);
    runLine(1'b1, 2, 111, 3, 1'b0, 1'b0);
    runLine(1'b1, 2, 112, 0, 1'b1, 1'b0);
    runLine(1'b1, 0, 5, 1, 1'b0, 1'b0);
    runLine(1'b1, 1, 1000, 1, 1'b1, 1'b0);
    // R9 stray start mid-line
    runLine(1'b0, 3, 0, 5, 1'b0, 1'b1);

    // random lines
    for (int i = 0; i < 6; i++) begin
      int h;
      h = $urandom_range(1, 4);
      runLine(1'($urandom_range(0, 1)), h, $urandom_range(0, 400),
              $urandom_range(0, 2 * h - 1), 1'b1, 1'($urandom_range(0, 1)));
    end

    // R6 continuous back-to-back lines
    setCfg(1'b1, 2, 150, 2);
    expBusy = 1;
    gapArm = 0;
    contPhase = 1;
    startCnt = lineCnt;
    @(posedge clk); #1 contMode = 1'b1;
    while (lineCnt < startCnt + 2) @(posedge clk);
    #1;
    contMode = 1'b0;
    expBusy = 0;
    while (lineCnt < startCnt + 3) @(posedge clk);
    #1;
    contPhase = 0;
    gapArm = 0;
    repeat (4) @(posedge clk);
    #1;
    check("R6 stops after contMode drops", int'(busy), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule